// File: doc/BRIEF.md
# Channel Configuration Register Target

This block is the software-facing register file of a multi-channel shared-memory messaging controller. It sits on a simple register bus. A request is presented for one cycle and a response comes back on the next cycle. Through it, software sets up each hardware channel and trades plain 32-bit words with an attached coprocessor. The channel datapath and its arbiter sit elsewhere and consume the per-channel outputs of this block.

Channels are set up indirectly. Software first writes a direction (toward the coprocessor or away from it) and a channel number within that direction. Five further registers then reach only the channel so selected: descriptor address, buffer address, depth in bytes, item width in bytes and a running flag. The lowest word offsets form a window onto the coprocessor. Reads return live status inputs and writes land in configuration output registers. A flush register clears every channel in one write and pulses a flush strobe to the channel FIFOs. Addresses beyond the map are answered with an error.

Top module: `chan_cfg_target`

## Requirements
- R1: After reset, the response outputs, the flush strobe, every coprocessor configuration word, every channel field and every running flag are zero.
- R2: Each cycle with `req_valid` high produces exactly one response (`rsp_valid` high) on the next cycle. A cycle without a request produces none. Write responses carry zero data.
- R3: A read at word offset i below IOREG returns the present value of status word i when i < N_STAT. It returns zero, without error, when N_STAT <= i < IOREG.
- R4: A write at word offset i below N_CFG loads configuration word i (`cop_config_o[32*i +: 32]`) from the write data. A write at N_CFG <= i < IOREG changes nothing and raises no error.
- R5: Offset IOREG+1 holds the direction select in bit 0, where 0 means toward the coprocessor and 1 means from it. Offset IOREG+2 holds the 32-bit channel number. Both read back as written.
- R6: Writes at IOREG+3 (descriptor address), IOREG+6 (buffer address), IOREG+4 (depth, bytes) and IOREG+5 (item width, bytes) update only the selected channel. Reads at those offsets return its field. Toward-coprocessor channel k is output slot k, and from-coprocessor channel k is slot N_TO+k.
- R7: A write at IOREG+7 sets the selected channel's running flag (`chan_run_o` bit = slot) to bit 0 of the write data. A read returns the flag in bit 0.
- R8: When the channel number is not below the channel count of the selected direction, accesses at IOREG+3..IOREG+7 change no channel state and are answered with an error and zero data.
- R9: A write at IOREG clears all channel fields, running flags, direction and number. `fifo_flush_o` is high for exactly the cycle of that write's response. Coprocessor configuration words are kept.
- R10: An access at offset IOREG+8 or above is answered with an error and zero data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DW | Read data |
| cop_status_i | input | N_STAT*DW | Coprocessor status words |
| cop_config_o | output | N_CFG*DW | Coprocessor configuration words |
| chan_desc_addr_o | output | NCH*DW | Descriptor address per channel slot |
| chan_buf_addr_o | output | NCH*DW | Buffer address per channel slot |
| chan_depth_o | output | NCH*DW | Channel depth in bytes per slot |
| chan_width_o | output | NCH*DW | Item width in bytes per slot |
| chan_run_o | output | NCH | Running flag per slot |
| fifo_flush_o | output | 1 | One-cycle flush strobe |

## Verification
Channel programming is tried with one selection in each direction, so that a wrong slot mapping shows up as data in the wrong slot while the neighbouring slots stay zero. Selections exactly at the channel count of each direction are asymmetric: a number of 2 is legal from the coprocessor but not toward it. These cases separate a correct per-direction limit from one shared limit. Status reads are repeated after the inputs change, to tell live reads from latched ones. The coprocessor window is probed on both sides of the status count and of the configuration count. The flush is checked both for what it clears and for what it must leave alone.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;

   // control register offsets relative to the end of the coprocessor window
   localparam int OFS_FLUSH = 0;
   localparam int OFS_DIR   = 1;
   localparam int OFS_NUM   = 2;
   localparam int OFS_DESC  = 3;
   localparam int OFS_DEPTH = 4;
   localparam int OFS_WIDTH = 5;
   localparam int OFS_BUF   = 6;
   localparam int OFS_RUN   = 7;
   localparam int NUM_CTRL  = 8;

   localparam logic DIR_TO_COP   = 1'b0;
   localparam logic DIR_FROM_COP = 1'b1;

   typedef enum logic [3:0] {
      K_COP, K_FLUSH, K_DIR, K_NUM, K_DESC,
      K_DEPTH, K_WIDTH, K_BUF, K_RUN, K_BAD
   } acc_kind_e;

endpackage

// File: rtl/chan_cfg_decode.sv
module chan_cfg_decode
   import chan_cfg_pkg::*;
#(
   parameter int IOREG  = 4,
   parameter int ADDR_W = 5
)(
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);
   localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'(IOREG);

   logic [ADDR_W-1:0] off;
   assign off = addr - IO_BASE;

   always_comb begin
      kind = K_BAD;
      if (addr < IO_BASE) kind = K_COP;
      else if (off == ADDR_W'(OFS_FLUSH)) kind = K_FLUSH;
      else if (off == ADDR_W'(OFS_DIR))   kind = K_DIR;
      else if (off == ADDR_W'(OFS_NUM))   kind = K_NUM;
      else if (off == ADDR_W'(OFS_DESC))  kind = K_DESC;
      else if (off == ADDR_W'(OFS_DEPTH)) kind = K_DEPTH;
      else if (off == ADDR_W'(OFS_WIDTH)) kind = K_WIDTH;
      else if (off == ADDR_W'(OFS_BUF))   kind = K_BUF;
      else if (off == ADDR_W'(OFS_RUN))   kind = K_RUN;
   end
endmodule

// File: rtl/chan_cfg_coproc.sv
module chan_cfg_coproc #(
   parameter int N_CFG  = 3,
   parameter int N_STAT = 2,
   parameter int IDX_W  = 5,
   parameter int DW     = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DW-1:0]       wdata,
   input  logic [N_STAT*DW-1:0] status_i,
   output logic [N_CFG*DW-1:0]  config_o,
   output logic [DW-1:0]       rd_data
);
   for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
      logic [DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             word_q <= '0;
         else if (wr_en && idx == IDX_W'(i))     word_q <= wdata;
      end
      assign config_o[i*DW +: DW] = word_q;

      // R4: an addressed write lands in its configuration word
      assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && idx == IDX_W'(i)) |=> config_o[i*DW +: DW] == $past(wdata));
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_STAT; i++)
         if (idx == IDX_W'(i)) rd_data = status_i[i*DW +: DW];
   end
endmodule

// File: rtl/chan_cfg_bank.sv
module chan_cfg_bank
   import chan_cfg_pkg::*;
#(
   parameter int NCH    = 5,
   parameter int SLOT_W = 3,
   parameter int DW     = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  acc_kind_e         kind,
   input  logic [SLOT_W-1:0] slot,
   input  logic [DW-1:0]     wdata,
   output logic [NCH*DW-1:0] desc_o,
   output logic [NCH*DW-1:0] buf_o,
   output logic [NCH*DW-1:0] depth_o,
   output logic [NCH*DW-1:0] width_o,
   output logic [NCH-1:0]    run_o,
   output logic [DW-1:0]     rd_data
);
   logic [DW-1:0] desc_q  [NCH];
   logic [DW-1:0] buf_q   [NCH];
   logic [DW-1:0] depth_q [NCH];
   logic [DW-1:0] width_q [NCH];
   logic          run_q   [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (slot == SLOT_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            desc_q[c]  <= '0;
            buf_q[c]   <= '0;
            depth_q[c] <= '0;
            width_q[c] <= '0;
            run_q[c]   <= 1'b0;
         end else if (flush) begin
            desc_q[c]  <= '0;
            buf_q[c]   <= '0;
            depth_q[c] <= '0;
            width_q[c] <= '0;
            run_q[c]   <= 1'b0;
         end else if (hit) begin
            case (kind)
               K_DESC:  desc_q[c]  <= wdata;
               K_BUF:   buf_q[c]   <= wdata;
               K_DEPTH: depth_q[c] <= wdata;
               K_WIDTH: width_q[c] <= wdata;
               K_RUN:   run_q[c]   <= wdata[0];
               default: ;
            endcase
         end
      end

      assign desc_o[c*DW +: DW]  = desc_q[c];
      assign buf_o[c*DW +: DW]   = buf_q[c];
      assign depth_o[c*DW +: DW] = depth_q[c];
      assign width_o[c*DW +: DW] = width_q[c];
      assign run_o[c]            = run_q[c];
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (slot == SLOT_W'(c)) begin
            case (kind)
               K_DESC:  rd_data = desc_q[c];
               K_BUF:   rd_data = buf_q[c];
               K_DEPTH: rd_data = depth_q[c];
               K_WIDTH: rd_data = width_q[c];
               K_RUN:   rd_data = DW'(run_q[c]);
               default: ;
            endcase
         end
      end
   end

   // R9: a flush leaves every channel stopped and cleared
   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (run_o == '0 && desc_o == '0 && buf_o == '0));
endmodule

// File: rtl/chan_cfg_target.sv
module chan_cfg_target
   import chan_cfg_pkg::*;
#(
   parameter int N_TO   = 2,
   parameter int N_FROM = 3,
   parameter int N_CFG  = 3,
   parameter int N_STAT = 2,
   parameter int IOREG  = 4,
   parameter int ADDR_W = 5,
   parameter int DW     = 32,
   localparam int NCH   = N_TO + N_FROM
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DW-1:0]        req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DW-1:0]        rsp_rdata,
   input  logic [N_STAT*DW-1:0] cop_status_i,
   output logic [N_CFG*DW-1:0]  cop_config_o,
   output logic [NCH*DW-1:0]    chan_desc_addr_o,
   output logic [NCH*DW-1:0]    chan_buf_addr_o,
   output logic [NCH*DW-1:0]    chan_depth_o,
   output logic [NCH*DW-1:0]    chan_width_o,
   output logic [NCH-1:0]       chan_run_o,
   output logic                 fifo_flush_o
);
   localparam int SLOT_W = (NCH > 1) ? $clog2(NCH) : 1;

   // elaboration-time parameter checks
   if (IOREG < N_CFG || IOREG < N_STAT) begin : g_bad_ioreg
      $error("IOREG must cover both coprocessor word counts");
   end
   if ((1 << ADDR_W) < IOREG + NUM_CTRL) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (N_TO < 1 || N_FROM < 1 || DW < 8) begin : g_bad_cnt
      $error("need at least one channel per direction and DW >= 8");
   end

   acc_kind_e     kind;
   logic          dir_q;
   logic [DW-1:0] num_q;
   logic [DW-1:0] lim;
   logic [DW-1:0] slot_wide;
   logic          sel_ok;
   logic          is_chan;
   logic          wr, flush_now, chan_wr, cop_wr;
   logic [DW-1:0] cop_rd, bank_rd, rd_mux;
   logic          err_now;

   chan_cfg_decode #(.IOREG(IOREG), .ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr),
      .kind (kind)
   );

   assign lim       = (dir_q == DIR_FROM_COP) ? DW'(N_FROM) : DW'(N_TO);
   assign sel_ok    = num_q < lim;
   assign slot_wide = (dir_q == DIR_FROM_COP) ? num_q + DW'(N_TO) : num_q;
   assign is_chan   = (kind == K_DESC) || (kind == K_DEPTH) || (kind == K_WIDTH) ||
                      (kind == K_BUF)  || (kind == K_RUN);
   assign wr        = req_valid && req_write;
   assign flush_now = wr && (kind == K_FLUSH);
   assign chan_wr   = wr && is_chan && sel_ok;
   assign cop_wr    = wr && (kind == K_COP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_TO_COP;
         num_q <= '0;
      end else if (flush_now) begin
         dir_q <= DIR_TO_COP;
         num_q <= '0;
      end else if (wr && kind == K_DIR) begin
         dir_q <= req_wdata[0];
      end else if (wr && kind == K_NUM) begin
         num_q <= req_wdata;
      end
   end

   chan_cfg_coproc #(.N_CFG(N_CFG), .N_STAT(N_STAT), .IDX_W(ADDR_W), .DW(DW)) u_cop (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cop_wr),
      .idx      (req_addr),
      .wdata    (req_wdata),
      .status_i (cop_status_i),
      .config_o (cop_config_o),
      .rd_data  (cop_rd)
   );

   chan_cfg_bank #(.NCH(NCH), .SLOT_W(SLOT_W), .DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_now),
      .wr_en   (chan_wr),
      .kind    (kind),
      .slot    (slot_wide[SLOT_W-1:0]),
      .wdata   (req_wdata),
      .desc_o  (chan_desc_addr_o),
      .buf_o   (chan_buf_addr_o),
      .depth_o (chan_depth_o),
      .width_o (chan_width_o),
      .run_o   (chan_run_o),
      .rd_data (bank_rd)
   );

   always_comb begin
      rd_mux  = '0;
      err_now = 1'b0;
      case (kind)
         K_COP:   rd_mux = cop_rd;
         K_DIR:   rd_mux = DW'(dir_q);
         K_NUM:   rd_mux = num_q;
         K_DESC, K_DEPTH, K_WIDTH, K_BUF, K_RUN: begin
            if (sel_ok) rd_mux  = bank_rd;
            else        err_now = 1'b1;
         end
         K_BAD:   err_now = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_err      <= 1'b0;
         rsp_rdata    <= '0;
         fifo_flush_o <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_err      <= req_valid && err_now;
         rsp_rdata    <= (req_valid && !req_write && !err_now) ? rd_mux : '0;
         fifo_flush_o <= flush_now;
      end
   end

   // R2: one response per request, none without
   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R8: a write through an out-of-range selection touches no channel
   assert_bad_sel_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && is_chan && !sel_ok) |=> (rsp_err && $stable(chan_run_o) &&
                                      $stable(chan_desc_addr_o) && $stable(chan_depth_o)));
   // R10: unmapped offsets answer with an error
   assert_bad_addr_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == K_BAD) |=> (rsp_err && rsp_rdata == '0));
   // R9: flush strobe only after a flush-register write
   assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_now |=> fifo_flush_o);
   assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_now |=> !fifo_flush_o);
endmodule

// File: tb/tb_chan_cfg_target.sv
module tb_chan_cfg_target;
   localparam int N_TO = 2, N_FROM = 3, N_CFG = 3, N_STAT = 2, IOREG = 4;
   localparam int ADDR_W = 5, DW = 32, NCH = 5;
   localparam int A_FLUSH = 4, A_DIR = 5, A_NUM = 6, A_DESC = 7, A_DEPTH = 8;
   localparam int A_WIDTH = 9, A_BUF = 10, A_RUN = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic rsp_valid, rsp_err, fifo_flush_o;
   logic [DW-1:0] rsp_rdata;
   logic [N_STAT*DW-1:0] cop_status_i = '0;
   logic [N_CFG*DW-1:0] cop_config_o;
   logic [NCH*DW-1:0] chan_desc_addr_o, chan_buf_addr_o, chan_depth_o, chan_width_o;
   logic [NCH-1:0] chan_run_o;

   chan_cfg_target dut (.*);

   always #10 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] rdata; logic err; string rq; } exp_t;
   exp_t sb[$];

   task automatic check(string rq, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", rq, got, exp);
      end
   endtask

   // driver: presents a request at a falling edge, records the expected response
   task automatic xact(bit wr, int addr, logic [31:0] wd,
                       logic [31:0] er, bit ee, string rq);
      req_valid = 1'b1; req_write = wr;
      req_addr = ADDR_W'(addr); req_wdata = wd;
      @(posedge clk);
      sb.push_back('{er, ee, rq});
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // monitor: compares each response against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (sb.size() == 0) begin
               vectors++; miscompares++;
               $display("FAIL R2: got unexpected response expected none");
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.rq, " data"}, rsp_rdata, e.rdata);
               check({e.rq, " err"}, 32'(rsp_err), 32'(e.err));
            end
         end else if (sb.size() != 0) begin
            vectors++; miscompares++;
            $display("FAIL R2: got no response expected one");
            sb.delete();
         end
      end
   end

   task automatic chk_slot(int s, logic [31:0] d, logic [31:0] b,
                           logic [31:0] dp, logic [31:0] w, string rq);
      check({rq, " desc"},  chan_desc_addr_o[s*DW +: DW], d);
      check({rq, " buf"},   chan_buf_addr_o[s*DW +: DW], b);
      check({rq, " depth"}, chan_depth_o[s*DW +: DW], dp);
      check({rq, " width"}, chan_width_o[s*DW +: DW], w);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++; miscompares++;
         $display("FAIL R2: got watchdog expiry expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rsp_valid", 32'(rsp_valid), 0);
      check("R1 rsp_err", 32'(rsp_err), 0);
      check("R1 flush", 32'(fifo_flush_o), 0);
      check("R1 config", 32'(cop_config_o != '0), 0);
      check("R1 run", 32'(chan_run_o), 0);
      check("R1 fields", 32'((chan_desc_addr_o | chan_buf_addr_o | chan_depth_o | chan_width_o) != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: live status reads, zero above the status count
      cop_status_i = {32'hBEEF_0001, 32'hCAFE_0000};
      xact(0, 0, 0, 32'hCAFE_0000, 0, "R3 status0");
      xact(0, 1, 0, 32'hBEEF_0001, 0, "R3 status1");
      xact(0, 2, 0, 32'h0, 0, "R3 gap2");
      xact(0, 3, 0, 32'h0, 0, "R3 gap3");
      cop_status_i = {32'h1234_5678, 32'h0BAD_F00D};
      xact(0, 0, 0, 32'h0BAD_F00D, 0, "R3 status0 live");
      xact(0, 1, 0, 32'h1234_5678, 0, "R3 status1 live");

      // R4: configuration words, write above the count ignored
      xact(1, 0, 32'h1111_0000, 0, 0, "R4 cfg0");
      xact(1, 2, 32'h2222_0002, 0, 0, "R4 cfg2");
      xact(1, 3, 32'hDEAD_DEAD, 0, 0, "R4 cfg gap");
      check("R4 cfg0", cop_config_o[0 +: 32], 32'h1111_0000);
      check("R4 cfg1", cop_config_o[32 +: 32], 32'h0);
      check("R4 cfg2", cop_config_o[64 +: 32], 32'h2222_0002);

      // R5/R6/R7: to-coprocessor channel 1 -> slot 1
      xact(1, A_DIR, 0, 0, 0, "R5 dir to");
      xact(1, A_NUM, 1, 0, 0, "R5 num");
      xact(0, A_NUM, 0, 1, 0, "R5 num readback");
      xact(0, A_DIR, 0, 0, 0, "R5 dir readback");
      xact(1, A_DESC, 32'hA000_0100, 0, 0, "R6 desc");
      xact(1, A_BUF, 32'hB000_0200, 0, 0, "R6 buf");
      xact(1, A_DEPTH, 64, 0, 0, "R6 depth");
      xact(1, A_WIDTH, 4, 0, 0, "R6 width");
      xact(1, A_RUN, 1, 0, 0, "R7 run");
      xact(0, A_DESC, 0, 32'hA000_0100, 0, "R6 desc readback");
      chk_slot(1, 32'hA000_0100, 32'hB000_0200, 64, 4, "R6 slot1");
      chk_slot(0, 0, 0, 0, 0, "R6 slot0 untouched");
      check("R7 run vec", 32'(chan_run_o), 32'b00010);

      // R5/R6/R7: from-coprocessor channel 2 -> slot 4 (highest legal number)
      xact(1, A_DIR, 1, 0, 0, "R5 dir from");
      xact(0, A_DIR, 0, 1, 0, "R5 dir from readback");
      xact(1, A_NUM, 2, 0, 0, "R5 num2");
      xact(1, A_DESC, 32'hC000_0300, 0, 0, "R6 desc from");
      xact(1, A_BUF, 32'hD000_0400, 0, 0, "R6 buf from");
      xact(1, A_DEPTH, 256, 0, 0, "R6 depth from");
      xact(1, A_WIDTH, 8, 0, 0, "R6 width from");
      xact(1, A_RUN, 2, 0, 0, "R7 run bit0 clear");
      xact(0, A_RUN, 0, 0, 0, "R7 run readback 0");
      xact(1, A_RUN, 3, 0, 0, "R7 run set");
      xact(0, A_RUN, 0, 1, 0, "R7 run readback 1");
      chk_slot(4, 32'hC000_0300, 32'hD000_0400, 256, 8, "R6 slot4");
      chk_slot(2, 0, 0, 0, 0, "R6 slot2 untouched");
      check("R7 run vec2", 32'(chan_run_o), 32'b10010);

      // R8: selection at the per-direction count
      xact(1, A_NUM, 3, 0, 0, "R8 num3");
      xact(1, A_DESC, 32'hFFFF_FFFF, 0, 1, "R8 desc from3");
      xact(1, A_RUN, 0, 0, 1, "R8 run from3");
      xact(0, A_DEPTH, 0, 0, 1, "R8 read from3");
      xact(1, A_DIR, 0, 0, 0, "R8 dir to");
      xact(1, A_NUM, 2, 0, 0, "R8 num2 to");
      xact(1, A_BUF, 32'hEEEE_EEEE, 0, 1, "R8 buf to2");
      check("R8 run kept", 32'(chan_run_o), 32'b10010);
      chk_slot(4, 32'hC000_0300, 32'hD000_0400, 256, 8, "R8 slot4 kept");
      chk_slot(1, 32'hA000_0100, 32'hB000_0200, 64, 4, "R8 slot1 kept");

      // R10: unmapped offsets
      xact(1, 12, 32'h5555_5555, 0, 1, "R10 write 12");
      xact(0, 31, 0, 0, 1, "R10 read 31");
      check("R10 run kept", 32'(chan_run_o), 32'b10010);
      check("R10 cfg kept", cop_config_o[0 +: 32], 32'h1111_0000);

      // R9: flush
      xact(1, A_FLUSH, 0, 0, 0, "R9 flush write");
      check("R9 flush high", 32'(fifo_flush_o), 1);
      check("R9 run cleared", 32'(chan_run_o), 0);
      chk_slot(1, 0, 0, 0, 0, "R9 slot1 cleared");
      chk_slot(4, 0, 0, 0, 0, "R9 slot4 cleared");
      check("R9 cfg kept", cop_config_o[64 +: 32], 32'h2222_0002);
      @(negedge clk);
      check("R9 flush one cycle", 32'(fifo_flush_o), 0);
      check("R2 idle no rsp", 32'(rsp_valid), 0);
      xact(0, A_DIR, 0, 0, 0, "R9 dir cleared");
      xact(0, A_NUM, 0, 0, 0, "R9 num cleared");
      xact(0, A_FLUSH, 0, 0, 0, "R9 flush read zero");

      @(negedge clk);
      done = 1'b1;
      if (sb.size() != 0) begin
         vectors++; miscompares++;
         $display("FAIL R2: got %0d pending expected 0", sb.size());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule